// File: doc/BRIEF.md
# Switch-Driven Adder Operand and Result Controller

This block is a clocked shell around a 16-bit adder. It is meant for a bench where one bank of switches and two pushbuttons are the only inputs. Operand A streams from the switches into a register on every clock. A load press captures the switches into operand B. A run press stores the sum of the two operand registers, together with its carry-out, into a result register. Each operand register is also shown as four hexadecimal digits on active-low seven-segment outputs.

A small control machine turns every press into exactly one action, however long the button is held. It cycles through the states Idle, Execute and Hold. Execute lasts one clock. Hold is left only once both buttons are released. If both buttons are seen at the same time, the load wins and the run is dropped. The adder inside is a carry-select adder built from 4-bit ripple groups. The lowest group has a single chain, and every higher group has a pair of chains, one for each possible carry-in.

Top module: `switch_adder_ctrl`

## Requirements
- R1: Operand A takes the switch value sampled at each clock edge, except at the edge where a load action is carried out; at that edge A keeps its previous value.
- R2: A load press copies the switch value present at the action edge into operand B. B changes at no other time except reset.
- R3: A run press sets {carry, sum} to the 17-bit sum of the operand registers. This appears one clock after the press is first sampled. The result holds at all other times.
- R4: Each press produces exactly one action. No further action happens until both buttons have been seen released.
- R5: When both buttons are sampled pressed in Idle, only the load is done. The run is not done, and the result does not change.
- R6: A synchronous, active-high reset clears A, B, the sum and the carry.
- R7: Loads and runs can be repeated any number of times without a reset between them.
- R8: Each operand digit drives 7 active-low segments, bit 0 = a through bit 6 = g. The 7-bit codes for nibbles 0..F are 40,79,24,30,19,12,02,78,00,10,08,03,46,21,06,0E (hex). Digit d takes bits [7d+6:7d] of the segment bus and shows nibble d of the operand.
- R9: The carry output is 1 exactly when the true sum exceeds FFFF (hex), for example FFFF + 0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw | input | 16 | Switch value |
| btn_load_b | input | 1 | Load-B button, active high |
| btn_run | input | 1 | Run button, active high |
| sum_q | output | 16 | Registered sum |
| cout_q | output | 1 | Registered carry-out |
| a_seg | output | 28 | Segment codes of operand A, four digits |
| b_seg | output | 28 | Segment codes of operand B, four digits |

## Verification
The hardest case to reach is the single clock in which a load is being carried out. In that clock A must hold while B captures.

The stimulus reaches it by changing the switches in the cycle between the press being sampled and the action edge. The bench then reads both segment buses right after that edge, where A still shows the old value and B already shows the new one.

A run held for several cycles while the switches change shows that only one result is produced. A run pressed during a held load, with the load then released, shows that both buttons must be released before the next action.

// File: rtl/sumctl_pkg.sv
package sumctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_HOLD = 2'd2
  } ctl_state_t;

  // One-bit full adder: returns {carry, sum}
  function automatic logic [1:0] full_add(input logic x, input logic y, input logic ci);
    full_add = {(x & y) | (ci & (x ^ y)), x ^ y ^ ci};
  endfunction

  // Active-low segment pattern, bit0 = a .. bit6 = g
  function automatic logic [6:0] hex_seg(input logic [3:0] n);
    case (n)
      4'h0: hex_seg = 7'h40;
      4'h1: hex_seg = 7'h79;
      4'h2: hex_seg = 7'h24;
      4'h3: hex_seg = 7'h30;
      4'h4: hex_seg = 7'h19;
      4'h5: hex_seg = 7'h12;
      4'h6: hex_seg = 7'h02;
      4'h7: hex_seg = 7'h78;
      4'h8: hex_seg = 7'h00;
      4'h9: hex_seg = 7'h10;
      4'hA: hex_seg = 7'h08;
      4'hB: hex_seg = 7'h03;
      4'hC: hex_seg = 7'h46;
      4'hD: hex_seg = 7'h21;
      4'hE: hex_seg = 7'h06;
      default: hex_seg = 7'h0E;
    endcase
  endfunction

endpackage

// File: rtl/sumctl_fsm.sv
module sumctl_fsm
  import sumctl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic btn_load_b,
  input  logic btn_run,
  output logic do_load,
  output logic do_run,
  output logic in_idle
);
  ctl_state_t state_q, state_d;
  logic       pick_load_q;
  logic       any_btn;

  assign any_btn = btn_load_b | btn_run;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (any_btn) state_d = ST_EXEC;
      ST_EXEC: state_d = ST_HOLD;
      ST_HOLD: if (!any_btn) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      pick_load_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && any_btn)
        pick_load_q <= btn_load_b;  // load has priority
    end
  end

  assign in_idle = (state_q == ST_IDLE);
  assign do_load = (state_q == ST_EXEC) &&  pick_load_q;
  assign do_run  = (state_q == ST_EXEC) && !pick_load_q;

endmodule

// File: rtl/sumctl_ripple.sv
module sumctl_ripple
  import sumctl_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] cy;
  assign cy[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign {cy[i+1], sum[i]} = full_add(a[i], b[i], cy[i]);
  end

  assign cout = cy[W];
endmodule

// File: rtl/sumctl_csel.sv
module sumctl_csel #(
  parameter int WIDTH = 16,
  parameter int GRP   = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NG = WIDTH / GRP;

  logic [NG:0] gc;
  assign gc[0] = cin;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    if (g == 0) begin : g_first
      sumctl_ripple #(.W(GRP)) u_rc (
        .a(a[GRP-1:0]), .b(b[GRP-1:0]), .cin(gc[0]),
        .sum(sum[GRP-1:0]), .cout(gc[1])
      );
    end else begin : g_pair
      logic [GRP-1:0] s0, s1;
      logic           c0, c1;
      sumctl_ripple #(.W(GRP)) u_rc0 (
        .a(a[g*GRP +: GRP]), .b(b[g*GRP +: GRP]), .cin(1'b0),
        .sum(s0), .cout(c0)
      );
      sumctl_ripple #(.W(GRP)) u_rc1 (
        .a(a[g*GRP +: GRP]), .b(b[g*GRP +: GRP]), .cin(1'b1),
        .sum(s1), .cout(c1)
      );
      assign sum[g*GRP +: GRP] = gc[g] ? s1 : s0;
      assign gc[g+1]           = gc[g] ? c1 : c0;
    end
  end

  assign cout = gc[NG];
endmodule

// File: rtl/sumctl_segs.sv
module sumctl_segs
  import sumctl_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] val,
  output logic [7*DIGITS-1:0] segs
);
  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    assign segs[d*7 +: 7] = hex_seg(val[d*4 +: 4]);
  end
endmodule

// File: rtl/switch_adder_ctrl.sv
module switch_adder_ctrl #(
  parameter int WIDTH = 16,
  parameter int GRP   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [WIDTH-1:0]         sw,
  input  logic                     btn_load_b,
  input  logic                     btn_run,
  output logic [WIDTH-1:0]         sum_q,
  output logic                     cout_q,
  output logic [7*(WIDTH/4)-1:0]   a_seg,
  output logic [7*(WIDTH/4)-1:0]   b_seg
);
  localparam int DIGITS = WIDTH / 4;

  logic [WIDTH-1:0] a_q, b_q, add_sum;
  logic             add_cout;
  logic             do_load, do_run, in_idle;

  sumctl_fsm u_fsm (
    .clk(clk), .rst(rst), .btn_load_b(btn_load_b), .btn_run(btn_run),
    .do_load(do_load), .do_run(do_run), .in_idle(in_idle)
  );

  sumctl_csel #(.WIDTH(WIDTH), .GRP(GRP)) u_add (
    .a(a_q), .b(b_q), .cin(1'b0), .sum(add_sum), .cout(add_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      if (!do_load) a_q <= sw;
      if (do_load)  b_q <= sw;
      if (do_run)   {cout_q, sum_q} <= {add_cout, add_sum};
    end
  end

  sumctl_segs #(.DIGITS(DIGITS)) u_aseg (.val(a_q), .segs(a_seg));
  sumctl_segs #(.DIGITS(DIGITS)) u_bseg (.val(b_q), .segs(b_seg));

endmodule

// File: rtl/switch_adder_ctrl_chk.sv
module switch_adder_ctrl_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] sw,
  input logic             btn_load_b,
  input logic             btn_run,
  input logic [WIDTH-1:0] a_q,
  input logic [WIDTH-1:0] b_q,
  input logic [WIDTH-1:0] sum_q,
  input logic             cout_q,
  input logic             do_load,
  input logic             do_run,
  input logic             in_idle
);
  assert_a_follow_R1: assert property (@(posedge clk) disable iff (rst)
    !do_load |=> a_q == $past(sw));
  assert_a_hold_R1: assert property (@(posedge clk) disable iff (rst)
    do_load |=> $stable(a_q));
  assert_b_capture_R2: assert property (@(posedge clk) disable iff (rst)
    do_load |=> b_q == $past(sw));
  assert_b_keep_R2: assert property (@(posedge clk) disable iff (rst)
    !do_load |=> $stable(b_q));
  assert_sum_R3: assert property (@(posedge clk) disable iff (rst)
    do_run |=> {cout_q, sum_q} == ({1'b0, $past(a_q)} + {1'b0, $past(b_q)}));
  assert_sum_keep_R3: assert property (@(posedge clk) disable iff (rst)
    !do_run |=> $stable({cout_q, sum_q}));
  assert_single_R4: assert property (@(posedge clk) disable iff (rst)
    (do_load || do_run) |=> !(do_load || do_run));
  assert_rearm_R4: assert property (@(posedge clk) disable iff (rst)
    ((btn_load_b || btn_run) && !in_idle) |=> !(do_load || do_run));
  assert_prio_R5: assert property (@(posedge clk) disable iff (rst)
    (in_idle && btn_load_b && btn_run) |=> (do_load && !do_run));
  assert_reset_R6: assert property (@(posedge clk)
    rst |=> (a_q == '0 && b_q == '0 && sum_q == '0 && !cout_q));
endmodule

bind switch_adder_ctrl switch_adder_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .sw(sw), .btn_load_b(btn_load_b), .btn_run(btn_run),
  .a_q(a_q), .b_q(b_q), .sum_q(sum_q), .cout_q(cout_q),
  .do_load(do_load), .do_run(do_run), .in_idle(in_idle)
);

// File: tb/test_switch_adder_ctrl.sv
module test_switch_adder_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] sw = '0;
  logic        bl = 1'b0;
  logic        br = 1'b0;
  logic [15:0] sum_q;
  logic        cout_q;
  logic [27:0] a_seg, b_seg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mute = 1'b1;
  logic [16:0] exp_q[$];
  logic [15:0] b_model = '0;

  always #4 clk = ~clk;

  switch_adder_ctrl i_switch_adder_ctrl (
    .clk(clk), .rst(rst), .sw(sw), .btn_load_b(bl), .btn_run(br),
    .sum_q(sum_q), .cout_q(cout_q), .a_seg(a_seg), .b_seg(b_seg)
  );

  function automatic logic [6:0] seg_ref(input logic [3:0] n);
    logic [6:0] tbl [16] = '{7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78,
                             7'h00, 7'h10, 7'h08, 7'h03, 7'h46, 7'h21, 7'h06, 7'h0E};
    return tbl[n];
  endfunction

  function automatic logic [27:0] segs_of(input logic [15:0] v);
    return {seg_ref(v[15:12]), seg_ref(v[11:8]), seg_ref(v[7:4]), seg_ref(v[3:0])};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: each change of the result pops one expected item
  initial begin
    logic [16:0] last = '0;
    forever begin
      @(negedge clk);
      if (mute || rst) last = {cout_q, sum_q};
      else if ({cout_q, sum_q} !== last) begin
        if (exp_q.size() == 0) chk("R4 unexpected result update", {cout_q, sum_q}, last);
        else chk("R3 R7 R9 result", {cout_q, sum_q}, exp_q.pop_front());
        last = {cout_q, sum_q};
      end
    end
  end

  task automatic load_b(input logic [15:0] first, input logic [15:0] second);
    sw = first;
    repeat (2) @(negedge clk);
    bl = 1'b1;
    @(negedge clk);
    sw = second;
    @(negedge clk);
    chk("R1 A holds during load", a_seg, segs_of(first));
    chk("R2 B captured", b_seg, segs_of(second));
    bl = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 A follows after load", a_seg, segs_of(second));
    b_model = second;
  endtask

  task automatic run_op(input logic [15:0] a_val, input int hold);
    sw = a_val;
    repeat (2) @(negedge clk);
    exp_q.push_back({1'b0, a_val} + {1'b0, b_model});
    br = 1'b1;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (i == 2) sw = ~a_val;
    end
    br = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R6 sum after reset", sum_q, 16'h0);
    chk("R6 carry after reset", cout_q, 1'b0);
    chk("R6 B after reset", b_seg, segs_of(16'h0));
    mute = 1'b0;

    // R8 / R1: all 16 digit codes through operand A
    foreach (sw_list[i]) begin
      sw = sw_list[i];
      repeat (2) @(negedge clk);
      chk("R8 R1 A segments", a_seg, segs_of(sw_list[i]));
    end

    load_b(16'hAAAA, 16'h1234);
    run_op(16'h0001, 2);                 // 0x01235
    run_op(16'hFFFF, 7);                 // R4 long hold with switch change: 0x11233
    chk("R4 single result under long hold", {cout_q, sum_q}, 17'h11233);
    load_b(16'h0F0F, 16'h0001);
    run_op(16'hFFFF, 1);                 // R9: 0x10000
    chk("R9 carry on FFFF+0001", cout_q, 1'b1);
    run_op(16'h7FFF, 3);                 // R7: 0x08000
    chk("R9 no carry", cout_q, 1'b0);

    // R5: both pressed together -> load only
    sw = 16'h5555;
    repeat (2) @(negedge clk);
    bl = 1'b1; br = 1'b1;
    repeat (4) @(negedge clk);
    bl = 1'b0; br = 1'b0;
    repeat (2) @(negedge clk);
    b_model = 16'h5555;
    chk("R5 load done on joint press", b_seg, segs_of(16'h5555));
    chk("R5 run suppressed", {cout_q, sum_q}, 17'h08000);

    // R4: run pressed while load held, load released -> no action
    bl = 1'b1;
    repeat (3) @(negedge clk);
    br = 1'b1;
    @(negedge clk);
    bl = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 no run until both released", {cout_q, sum_q}, 17'h08000);
    br = 1'b0;
    repeat (2) @(negedge clk);

    run_op(16'h0001, 2);                 // R7: 0x05556
    chk("R3 pending results drained", exp_q.size(), 0);

    // R6: reset mid-operation
    mute = 1'b1;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 sum cleared", {cout_q, sum_q}, 17'h0);
    chk("R6 A cleared", a_seg, segs_of(16'h0));
    chk("R6 B cleared", b_seg, segs_of(16'h0));
    rst = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  logic [15:0] sw_list [4] = '{16'h0123, 16'h4567, 16'h89AB, 16'hCDEF};

endmodule